// File: doc/BRIEF.md
# Dual-Output Vectored Interrupt Controller

This block gathers 32 level interrupt inputs and presents them to a processor as two request lines: a normal request and a fast request. Every input first passes through a shared conditioning stage that can invert it and can turn it into a latched (sticky) event. The conditioned bits are then judged by two independent output banks. Each bank has its own enable mask and its own priority threshold. Both banks use one shared table of 4-bit per-source priorities.

Software reaches all state through a simple word-addressed register port. The read data is combinational in the same cycle as the read strobe, and read side effects take place at the following clock edge. A handler loops on a bank's masked status. It reads the bank's current-source register to learn which source has won, services that source, and reads the bank's acknowledge register to drop the latched event. The loop ends when the masked status reads zero.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset the normal and fast request outputs are low, and every enable mask, threshold, priority, sticky select and latch is zero. The polarity select reads 0xFFFFFFFF, so no source is inverted.
- R2: In a bank, writing bank offset 0x008 sets the mask bits where the data has ones, and writing 0x00C clears the mask bits where the data has ones. Zero data bits leave the mask unchanged. A read of 0x008 returns the mask and a read of 0x00C returns 0.
- R3: The polarity select at 0x200 passes source i unchanged when bit i is 1 and inverts it when bit i is 0. The raw status at bank offset 0x004 shows the conditioned bits before the mask is applied.
- R4: A source whose sticky bit (register 0x204) is 0 is level-following: its raw status tracks the conditioned input in the same cycle.
- R5: A source whose sticky bit is 1 latches a conditioned high level. The latch stays set after the input drops, until that source is acknowledged.
- R6: Masked status (bank offset 0x000) is raw & mask & eligible. A source is eligible when its priority value is less than or equal to the bank threshold (bank offset 0x02C, low 4 bits). A threshold of 15 accepts every source.
- R7: Bank offset 0x020 reads the index of the masked-pending source with the smallest priority value. On a tie the lowest index wins. It reads 0 when nothing is masked-pending.
- R8: A read of bank offset 0x028 returns the current index and, at that clock edge, clears the sticky latch of that source, but only when the bank has a masked-pending source. It has no effect on level-mode sources.
- R9: The priority of source i is held at 0x300 + 4*i in the low 4 bits, and the threshold is held in the low 4 bits of its register. Both read back zero-extended.
- R10: The normal bank sits at base 0x000 and drives irq_o. The fast bank sits at base 0x100 and drives fiq_o. Masks and thresholds are separate for each bank, while conditioning and priorities are shared.
- R11: Each request output is registered. It rises one clock after the bank's masked status turns nonzero and falls one clock after it turns zero.
- R12: Reads of unmapped or non-word-aligned addresses return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs |
| addr_i | input | 12 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; side effects occur at the clock edge |
| rdata_o | output | 32 | Read data, valid in the cycle of rd_en_i |
| irq_o | output | 1 | Normal request, registered |
| fiq_o | output | 1 | Fast request, registered |

## Verification
The bench walks a single active source across all 32 positions in both banks, so a wrong bit-to-index mapping or a stuck mask bit shows up as a wrong current index. It loads a priority table with repeated values and sweeps the threshold over all 16 settings. A design that picks the highest index on ties, or compares the threshold the wrong way round, then reports a different winner or status. Sticky events are acknowledged one at a time. A design that clears every latch, or clears one on a read taken while nothing is pending, would lose the second event. Unmapped and misaligned accesses are checked so that aliasing decoders are caught, and the one-clock request delay is checked on both edges.

// File: rtl/intc_pkg.sv
// Package: shared constants and region codes for the dual-bank interrupt controller.
// Assumes byte addresses of 12 bits, with bits [11:8] selecting a region.
package intc_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned ADR_W = 12;

    // Offsets inside a bank region
    localparam logic [7:0] OFS_MSTAT = 8'h00;
    localparam logic [7:0] OFS_RAW   = 8'h04;
    localparam logic [7:0] OFS_EN    = 8'h08;
    localparam logic [7:0] OFS_DIS   = 8'h0C;
    localparam logic [7:0] OFS_CUR   = 8'h20;
    localparam logic [7:0] OFS_ACK   = 8'h28;
    localparam logic [7:0] OFS_THR   = 8'h2C;

    // Offsets inside the configuration region
    localparam logic [7:0] OFS_PASS   = 8'h00;
    localparam logic [7:0] OFS_STICKY = 8'h04;

    typedef enum logic [3:0] {
        RGN_NORMAL = 4'h0,
        RGN_FAST   = 4'h1,
        RGN_CFG    = 4'h2,
        RGN_PRIO   = 4'h3
    } region_e;
endpackage

// File: rtl/intc_src_cond.sv
// Module: per-source conditioning. Applies optional inversion and an optional sticky latch.
// Assumes src_i is already synchronous to clk. clr_i is one-hot or zero (an acknowledge).
module intc_src_cond #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pass_i,
    input  logic [N-1:0] sticky_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] raw_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic cond;
        logic latch_q;

        // Polarity: 1 passes the input through, 0 inverts it
        assign cond = pass_i[i] ? src_i[i] : ~src_i[i];

        // Sticky latch: set by a conditioned high, cleared by acknowledge or in level mode
        always_ff @(posedge clk) begin
            if (!rst_n || !sticky_i[i]) latch_q <= 1'b0;
            else                        latch_q <= (latch_q | cond) & ~clr_i[i];
        end

        // Select the level or latched view
        assign raw_o[i] = sticky_i[i] ? latch_q : cond;

        // R5: a latched event survives until acknowledged
        a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_i[i] && latch_q && !clr_i[i] && $stable(sticky_i[i])) |=> latch_q)
            else $error("latch lost without acknowledge");
    end
endmodule

// File: rtl/intc_bank.sv
// Module: one output bank. Holds the enable mask and threshold, forms the masked status,
// picks the winner (smallest priority value, then lowest index) and registers the request.
// Assumes en_set_i and en_clr_i are never nonzero in the same cycle.
module intc_bank #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          raw_i,
    input  logic [N-1:0][PW-1:0]  prio_i,
    input  logic [N-1:0]          en_set_i,
    input  logic [N-1:0]          en_clr_i,
    input  logic                  thr_we_i,
    input  logic [PW-1:0]         thr_d_i,
    output logic [N-1:0]          mask_o,
    output logic [N-1:0]          mstat_o,
    output logic [IW-1:0]         cur_o,
    output logic [PW-1:0]         thr_o,
    output logic                  req_o
);
    logic [N-1:0]  mask_q;
    logic [PW-1:0] thr_q;
    logic [N-1:0]  elig;
    logic          req_q;
    logic [IW-1:0] best;
    logic [PW-1:0] best_p;
    logic          found;

    // Enable mask: write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | en_set_i) & ~en_clr_i;
    end

    // Priority threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_q <= '0;
        else if (thr_we_i) thr_q <= thr_d_i;
    end

    // Eligibility: priority value at or below the threshold
    always_comb begin
        for (int i = 0; i < N; i++) elig[i] = (prio_i[i] <= thr_q);
    end

    assign mstat_o = raw_i & mask_q & elig;

    // Winner pick: a strict compare keeps the lowest index on ties
    always_comb begin
        found  = 1'b0;
        best   = '0;
        best_p = '1;
        for (int i = 0; i < N; i++) begin
            if (mstat_o[i] && (!found || prio_i[i] < best_p)) begin
                found  = 1'b1;
                best   = IW'(i);
                best_p = prio_i[i];
            end
        end
    end

    // Registered request output
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |mstat_o;
    end

    assign mask_o = mask_q;
    assign thr_o  = thr_q;
    assign cur_o  = best;
    assign req_o  = req_q;

    // R7: the reported winner is itself masked-pending
    a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|mstat_o) |-> mstat_o[cur_o]) else $error("winner not pending");
    // R7: with nothing pending the index reads zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(|mstat_o) |-> (cur_o == '0)) else $error("idle index nonzero");
    // R6: the winner respects the threshold
    a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (|mstat_o) |-> (prio_i[cur_o] <= thr_q)) else $error("winner above threshold");
    // R2: set bits land in the mask
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i != '0) |=> ((mask_q & $past(en_set_i)) == $past(en_set_i)))
        else $error("enable write lost");
    // R2: clear bits leave the mask
    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr_i != '0) |=> ((mask_q & $past(en_clr_i)) == '0))
        else $error("disable write lost");
    // R11: the request rises only after a pending cycle
    a_r11_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(|mstat_o)) else $error("request rose without pending");
endmodule

// File: rtl/dual_bank_intc.sv
// Module: top of the dual-bank interrupt controller. Decodes the register port, holds the
// shared polarity, sticky and priority settings, and instantiates conditioning and two banks.
// Assumes at most one access per cycle and N no larger than the 32-bit data word.
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         src_i,
    input  logic [ADR_W-1:0]     addr_i,
    input  logic                 wr_en_i,
    input  logic [BUS_W-1:0]     wdata_i,
    input  logic                 rd_en_i,
    output logic [BUS_W-1:0]     rdata_o,
    output logic                 irq_o,
    output logic                 fiq_o
);
    localparam int unsigned NB = 2;
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [3:0]              rgn;
    logic [7:0]              ofs;
    logic                    aligned;
    logic [5:0]              pidx;
    logic                    cfg_hit;
    logic                    pri_hit;
    logic [N-1:0]            pass_q;
    logic [N-1:0]            sticky_q;
    logic [N-1:0][PW-1:0]    prio_q;
    logic [N-1:0]            raw;
    logic [N-1:0]            clr;
    logic [NB-1:0][N-1:0]    b_clr;
    logic [NB-1:0][N-1:0]    b_mask;
    logic [NB-1:0][N-1:0]    b_mstat;
    logic [NB-1:0][IW-1:0]   b_cur;
    logic [NB-1:0][PW-1:0]   b_thr;
    logic [NB-1:0]           b_req;
    logic [NB-1:0]           b_hit;

    assign rgn     = addr_i[11:8];
    assign ofs     = addr_i[7:0];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign pidx    = addr_i[7:2];
    assign cfg_hit = aligned && (rgn == RGN_CFG);
    assign pri_hit = aligned && (rgn == RGN_PRIO) && (32'(pidx) < N);

    // Shared polarity and sticky selects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q   <= '1;
            sticky_q <= '0;
        end else if (wr_en_i && cfg_hit) begin
            if (ofs == OFS_PASS)   pass_q   <= wdata_i[N-1:0];
            if (ofs == OFS_STICKY) sticky_q <= wdata_i[N-1:0];
        end
    end

    // Shared per-source priority table
    always_ff @(posedge clk) begin
        if (!rst_n)                    prio_q <= '0;
        else if (wr_en_i && pri_hit)   prio_q[pidx[IW-1:0]] <= wdata_i[PW-1:0];
    end

    intc_src_cond #(.N(N)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .pass_i   (pass_q),
        .sticky_i (sticky_q),
        .clr_i    (clr),
        .raw_o    (raw)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [N-1:0] set_v;
        logic [N-1:0] dis_v;
        logic         thr_we;

        assign b_hit[b] = aligned && (rgn == 4'(b));
        assign set_v    = (wr_en_i && b_hit[b] && ofs == OFS_EN)  ? wdata_i[N-1:0] : '0;
        assign dis_v    = (wr_en_i && b_hit[b] && ofs == OFS_DIS) ? wdata_i[N-1:0] : '0;
        assign thr_we   = wr_en_i && b_hit[b] && (ofs == OFS_THR);
        // Acknowledge only when the bank really has a winner
        assign b_clr[b] = (rd_en_i && b_hit[b] && ofs == OFS_ACK && |b_mstat[b])
                          ? (N'(1) << b_cur[b]) : '0;

        intc_bank #(.N(N), .PW(PW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (raw),
            .prio_i   (prio_q),
            .en_set_i (set_v),
            .en_clr_i (dis_v),
            .thr_we_i (thr_we),
            .thr_d_i  (wdata_i[PW-1:0]),
            .mask_o   (b_mask[b]),
            .mstat_o  (b_mstat[b]),
            .cur_o    (b_cur[b]),
            .thr_o    (b_thr[b]),
            .req_o    (b_req[b])
        );
    end

    assign clr   = b_clr[0] | b_clr[1];
    assign irq_o = b_req[0];
    assign fiq_o = b_req[1];

    // Read multiplexer: unmapped or misaligned addresses return zero
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            if (cfg_hit) begin
                if (ofs == OFS_PASS)   rdata_o = BUS_W'(pass_q);
                if (ofs == OFS_STICKY) rdata_o = BUS_W'(sticky_q);
            end else if (pri_hit) begin
                rdata_o = BUS_W'(prio_q[pidx[IW-1:0]]);
            end else begin
                for (int b = 0; b < NB; b++) begin
                    if (b_hit[b]) begin
                        case (ofs)
                            OFS_MSTAT: rdata_o = BUS_W'(b_mstat[b]);
                            OFS_RAW:   rdata_o = BUS_W'(raw);
                            OFS_EN:    rdata_o = BUS_W'(b_mask[b]);
                            OFS_CUR,
                            OFS_ACK:   rdata_o = BUS_W'(b_cur[b]);
                            OFS_THR:   rdata_o = BUS_W'(b_thr[b]);
                            default:   rdata_o = '0;
                        endcase
                    end
                end
            end
        end
    end

    // R8: an acknowledge clears at most one latch
    a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)) else $error("acknowledge hit several sources");
    // R11: the normal request falls one clock after its bank empties
    a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(|b_mstat[0])) |=> !irq_o) else $error("request held too long");
    // R12: a write to an unmapped address leaves the polarity select alone
    a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !aligned) |=> $stable(pass_q)) else $error("misaligned write took effect");
endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src;
    logic [11:0] addr;
    logic        wr_en;
    logic [31:0] wdata;
    logic        rd_en;
    logic [31:0] rdata;
    logic        irq, fiq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int pm [32];

    always #5 clk = ~clk;

    dual_bank_intc u_dual_bank_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
        .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    // Model of the masked status under thresholds and the priority table pm
    function automatic logic [31:0] mdl_mstat(input logic [31:0] pend, input int thr);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) if (pend[i] && pm[i] <= thr) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] mdl_cur(input logic [31:0] ms);
        int bi = 0; int bp = 99;
        for (int i = 0; i < 32; i++) if (ms[i] && pm[i] < bp) begin bi = i; bp = pm[i]; end
        return 32'(bi);
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, pat, ms;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_5678;
        pats[2] = 32'h8000_0001; pats[3] = 32'hF0F0_F0F0;
        for (int i = 0; i < 32; i++) pm[i] = 0;
        src = '0; addr = '0; wr_en = 0; wdata = '0; rd_en = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 fiq", {31'b0, fiq}, 0);
        for (int b = 0; b < 2; b++) begin
            rchk("R1 mstat", 12'(b*256 + 'h00), 0);
            rchk("R1 raw",   12'(b*256 + 'h04), 0);
            rchk("R1 mask",  12'(b*256 + 'h08), 0);
            rchk("R1 cur",   12'(b*256 + 'h20), 0);
            rchk("R1 thr",   12'(b*256 + 'h2C), 0);
        end
        rchk("R1 polarity", 12'h200, 32'hFFFF_FFFF);
        rchk("R1 sticky", 12'h204, 0);
        rchk("R1 prio", 12'h314, 0);

        // R2 enable and disable
        wr(12'h008, 32'hA5A5_0F0F);
        rchk("R2 set", 12'h008, 32'hA5A5_0F0F);
        wr(12'h00C, 32'h0000_0F00);
        rchk("R2 clear", 12'h008, 32'hA5A5_000F);
        wr(12'h008, 32'h0000_0000);
        rchk("R2 zero write", 12'h008, 32'hA5A5_000F);
        rchk("R2 disable reads zero", 12'h00C, 0);
        rchk("R10 other bank untouched", 12'h108, 0);

        // R4 R7 R10: single source sweep over both banks
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h108, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); src = 32'h1 << i;
            for (int b = 0; b < 2; b++) begin
                rchk("R4 mstat", 12'(b*256), 32'h1 << i);
                rchk("R7 cur", 12'(b*256 + 'h20), 32'(i));
            end
            chk("R10 irq", {31'b0, irq}, 1);
            chk("R10 fiq", {31'b0, fiq}, 1);
        end
        @(negedge clk); src = '0;
        rchk("R7 none", 12'h020, 0);
        rchk("R4 level drop", 12'h004, 0);

        // R3 polarity
        wr(12'h200, 32'hFFFF_0000);
        foreach (pats[k]) begin
            @(negedge clk); src = pats[k];
            rchk("R3 raw", 12'h004, (pats[k] & 32'hFFFF_0000) | (~pats[k] & 32'h0000_FFFF));
        end
        wr(12'h200, 32'hFFFF_FFFF);

        // R9 R6 R7 priorities and threshold sweep
        for (int i = 0; i < 32; i++) begin
            pm[i] = (i * 7 + 3) % 16;
            wr(12'(12'h300 + 4*i), 32'hFFFF_FFF0 | 32'(pm[i]));
        end
        for (int i = 0; i < 32; i++) rchk("R9 prio", 12'(12'h300 + 4*i), 32'(pm[i]));
        wr(12'h02C, 32'hFFFF_FFFF);
        rchk("R9 thr", 12'h02C, 32'hF);
        foreach (pats[k]) begin
            @(negedge clk); src = pats[k];
            for (int t = 0; t < 16; t++) begin
                wr(12'h02C, 32'(t));
                ms = mdl_mstat(pats[k], t);
                rchk("R6 mstat", 12'h000, ms);
                rchk("R7 cur tie", 12'h020, mdl_cur(ms));
            end
        end

        // R10 independent thresholds and masks
        @(negedge clk); src = 32'hFFFF_FFFF;
        wr(12'h02C, 32'h0);
        wr(12'h12C, 32'hF);
        rchk("R10 bank0", 12'h000, mdl_mstat(32'hFFFF_FFFF, 0));
        rchk("R10 bank1", 12'h100, 32'hFFFF_FFFF);
        wr(12'h10C, 32'hFFFF_FFEF);
        rchk("R10 bank1 mask", 12'h108, 32'h0000_0010);
        rchk("R10 bank0 mask", 12'h008, 32'hFFFF_FFFF);
        rchk("R10 bank1 cur", 12'h120, 32'd4);

        // R5 R8 sticky and acknowledge
        for (int i = 0; i < 32; i++) begin pm[i] = 0; wr(12'(12'h300 + 4*i), 0); end
        @(negedge clk); src = '0;
        wr(12'h02C, 32'hF);
        wr(12'h204, 32'hFFFF_FFFF);
        rchk("R8 empty ack", 12'h028, 0);
        @(negedge clk); src = 32'h0000_0208;
        @(negedge clk); src = '0;
        rchk("R5 latched", 12'h004, 32'h0000_0208);
        rchk("R5 cur", 12'h020, 32'd3);
        rchk("R8 ack index", 12'h028, 32'd3);
        rchk("R8 one cleared", 12'h004, 32'h0000_0200);
        rchk("R8 next", 12'h020, 32'd9);
        rchk("R8 ack index 2", 12'h028, 32'd9);
        rchk("R8 all clear", 12'h000, 0);
        chk("R11 irq fell", {31'b0, irq}, 0);
        wr(12'h204, 32'h0);
        @(negedge clk); src = 32'h0000_0020;
        rchk("R8 level ack", 12'h028, 32'd5);
        rchk("R8 level unaffected", 12'h004, 32'h0000_0020);
        @(negedge clk); src = '0;

        // R12 unmapped and misaligned
        rchk("R12 gap", 12'h040, 0);
        rchk("R12 cfg gap", 12'h208, 0);
        rchk("R12 region", 12'h400, 0);
        rchk("R12 top", 12'hFFC, 0);
        rchk("R12 misaligned", 12'h009, 0);
        wr(12'h00D, 32'hFFFF_FFFF);
        wr(12'h201, 32'h0);
        wr(12'h400, 32'h0);
        rchk("R12 mask kept", 12'h108, 32'h0000_0010);
        rchk("R12 polarity kept", 12'h200, 32'hFFFF_FFFF);

        // R11 request timing
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0000_0001);
        @(negedge clk); src = 32'h1;
        #1 chk("R11 not yet", {31'b0, irq}, 0);
        @(negedge clk); chk("R11 rose", {31'b0, irq}, 1);
        src = '0;
        #1 chk("R11 held", {31'b0, irq}, 1);
        @(negedge clk); chk("R11 fell", {31'b0, irq}, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule